// File: doc/BRIEF.md
# Single-Bit Test-and-Modify Execution Unit

This unit executes the single-bit instruction class of a 32-bit core that has sixteen general registers and a one-bit test flag (T). A short form works on bit 0 to 7 of a register and finishes in the cycle it is issued. A long form is issued as a pair of halfwords and works on one bit of a byte in memory. That byte sits at a base register plus an unsigned 12-bit displacement. The unit reads the byte, modifies it and writes it back when required, in a fixed three-cycle sequence. Depending on the operation, the result goes into the addressed bit or into T.

The surrounding core presents both halfwords together with `issue_valid`. The unit reads its base or target register through a combinational register-file read port and writes a modified register back through a one-cycle write strobe. It reaches memory through a byte port whose read data returns one cycle after the read strobe. The core waits for `done` before it presents the next instruction.

The sequencer has three states. ST_IDLE accepts an instruction. From ST_IDLE, a register-form or illegal instruction completes in place (IDLE→IDLE). A memory-form instruction issues the byte read and moves IDLE→CAPTURE. In ST_CAPTURE the returned byte is taken and the new bit or new T is computed (CAPTURE→WRITE). In ST_WRITE the byte write is issued for the modifying operations only, and the sequencer returns WRITE→IDLE. A synchronous reset forces ST_IDLE and clears T.

Top module: `bitop_unit`

## Requirements
- R1: After synchronous reset, `t_flag`, `busy`, `done`, `illegal`, `rf_we`, `mem_re` and `mem_we` are all 0.
- R2: Register form `10000110nnnn0iii` clears bit iii of Rn, `10000110nnnn1iii` sets it, and `10000111nnnn0iii` copies T into it. Rn is written back in the issue cycle with every other bit unchanged, and T is unchanged.
- R3: Register form `10000111nnnn1iii` copies bit iii of Rn into T and leaves Rn unchanged.
- R4: A memory-form instruction has first halfword `0011nnnn0iii1001` and second halfword `oooo` followed by disp[11:0]. It issues a byte read in its issue cycle at Rn + zero-extended disp, computed modulo 2^32.
- R5: Memory opcodes 0011 (T=b), 0100 (T=b&T), 0101 (T=b|T), 0110 (T=b^T), 1011 (T=~b), 1100 (T=~b&T) and 1101 (T=~b|T) update only T, where b is the addressed bit. They issue no memory write.
- R6: Memory opcodes 0000 (bit=0), 0001 (bit=1) and 0010 (bit=T) write the byte back to the same address two cycles after the read, with only bit iii changed. T is unchanged.
- R7: `done` pulses one cycle after issue for a register form and three cycles after issue for a memory form. `busy` is high in between, and at most one of `rf_we`, `mem_re` and `mem_we` is high in any cycle.
- R8: `issue_valid` is ignored while `busy` is high.
- R9: Each of the following is illegal: a memory-form opcode outside the R5 and R6 lists, a memory-form first halfword with bit 7 set (`0011nnnn1iii1001`), and any other first halfword. An illegal instruction pulses `illegal` together with `done` one cycle after issue and changes no register, no memory byte and no T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | Instruction presented, sampled in ST_IDLE |
| insn_hi | input | 16 | First halfword |
| insn_lo | input | 16 | Second halfword (memory form only) |
| busy | output | 1 | Memory sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Completed instruction was illegal (with done) |
| t_flag | output | 1 | Current T flag |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | XLEN | Register-file read data (combinational) |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | 4 | Register write index |
| rf_wdata | output | XLEN | Register write data |
| mem_re | output | 1 | Byte read strobe |
| mem_we | output | 1 | Byte write strobe |
| mem_addr | output | XLEN | Byte address |
| mem_wdata | output | 8 | Byte write data |
| mem_rdata | input | 8 | Byte read data, valid the cycle after mem_re |

## Verification
The bench exercises bit positions 0 and 7 with T both set and clear. A design that indexes the wrong bit, or that inverts T instead of the bit in the NOT variants, gives a wrong T or a wrong byte. It uses a base of 0xFFFFF000 with the largest displacement, which catches a sign-extended or truncated address sum. It also counts memory writes per instruction, so a spurious write-back after a load or test is reported even when the byte value would be the same. Finally it issues a second instruction while the unit is busy, and it issues illegal opcodes and illegal first halfwords. Both catch a unit that accepts work mid-sequence or that still executes an illegal pattern.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    // Operation codes share values with the second-halfword opcode nibble.
    typedef enum logic [3:0] {
        BOP_CLR  = 4'h0,
        BOP_SET  = 4'h1,
        BOP_STT  = 4'h2,
        BOP_LD   = 4'h3,
        BOP_AND  = 4'h4,
        BOP_OR   = 4'h5,
        BOP_XOR  = 4'h6,
        BOP_LDN  = 4'hB,
        BOP_ANDN = 4'hC,
        BOP_ORN  = 4'hD,
        BOP_BAD  = 4'hF
    } bop_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_WRITE   = 2'd2
    } seq_e;

    typedef struct packed {
        logic        legal;
        logic        mem_form;
        bop_e        op;
        logic [3:0]  rn;
        logic [2:0]  idx;
        logic [11:0] disp;
    } bdec_t;

    function automatic logic op_writes(input bop_e op);
        return (op == BOP_CLR) || (op == BOP_SET) || (op == BOP_STT);
    endfunction

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
    import bitop_pkg::*;
(
    input  logic [15:0] insn_hi,
    input  logic [15:0] insn_lo,
    output bdec_t       dec
);

    logic reg_hit;
    logic mem_hit;
    bop_e mem_op;

    assign reg_hit = (insn_hi[15:9] == 7'b1000011);
    assign mem_hit = (insn_hi[15:12] == 4'h3) && (insn_hi[3:0] == 4'h9);

    always_comb begin
        case (insn_lo[15:12])
            4'h0:    mem_op = BOP_CLR;
            4'h1:    mem_op = BOP_SET;
            4'h2:    mem_op = BOP_STT;
            4'h3:    mem_op = BOP_LD;
            4'h4:    mem_op = BOP_AND;
            4'h5:    mem_op = BOP_OR;
            4'h6:    mem_op = BOP_XOR;
            4'hB:    mem_op = BOP_LDN;
            4'hC:    mem_op = BOP_ANDN;
            4'hD:    mem_op = BOP_ORN;
            default: mem_op = BOP_BAD;
        endcase
    end

    always_comb begin
        dec          = '0;
        dec.op       = BOP_BAD;
        dec.disp     = insn_lo[11:0];
        if (reg_hit) begin
            dec.legal    = 1'b1;
            dec.mem_form = 1'b0;
            dec.rn       = insn_hi[7:4];
            dec.idx      = insn_hi[2:0];
            case ({insn_hi[8], insn_hi[3]})
                2'b00:   dec.op = BOP_CLR;
                2'b01:   dec.op = BOP_SET;
                2'b10:   dec.op = BOP_STT;
                default: dec.op = BOP_LD;
            endcase
        end else if (mem_hit) begin
            dec.mem_form = 1'b1;
            dec.rn       = insn_hi[11:8];
            dec.idx      = insn_hi[6:4];
            dec.op       = mem_op;
            dec.legal    = !insn_hi[7] && (mem_op != BOP_BAD);
        end
    end

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
    import bitop_pkg::*;
(
    input  bop_e op,
    input  logic bit_in,
    input  logic t_in,
    output logic bit_out,
    output logic t_out
);

    always_comb begin
        bit_out = bit_in;
        t_out   = t_in;
        case (op)
            BOP_CLR:  bit_out = 1'b0;
            BOP_SET:  bit_out = 1'b1;
            BOP_STT:  bit_out = t_in;
            BOP_LD:   t_out   = bit_in;
            BOP_AND:  t_out   = bit_in & t_in;
            BOP_OR:   t_out   = bit_in | t_in;
            BOP_XOR:  t_out   = bit_in ^ t_in;
            BOP_LDN:  t_out   = ~bit_in;
            BOP_ANDN: t_out   = ~bit_in & t_in;
            BOP_ORN:  t_out   = ~bit_in | t_in;
            default: begin
                bit_out = bit_in;
                t_out   = t_in;
            end
        endcase
    end

endmodule

// File: rtl/bitop_lane.sv
module bitop_lane #(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [IW-1:0] idx,
    input  logic          new_bit,
    output logic          bit_sel,
    output logic [W-1:0]  dout
);

    assign bit_sel = din[idx];

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = (idx == IW'(i)) ? new_bit : din[i];
    end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int BYTEW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_valid,
    input  logic [15:0]      insn_hi,
    input  logic [15:0]      insn_lo,
    output logic             busy,
    output logic             done,
    output logic             illegal,
    output logic             t_flag,
    output logic [3:0]       rf_raddr,
    input  logic [XLEN-1:0]  rf_rdata,
    output logic             rf_we,
    output logic [3:0]       rf_waddr,
    output logic [XLEN-1:0]  rf_wdata,
    output logic             mem_re,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [BYTEW-1:0] mem_wdata,
    input  logic [BYTEW-1:0] mem_rdata
);

    localparam int RIW = $clog2(XLEN);
    localparam int BIW = $clog2(BYTEW);

    bdec_t dec;

    seq_e             state_q, state_d;
    bop_e             op_q;
    logic [2:0]       idx_q;
    logic [XLEN-1:0]  addr_q;
    logic [BYTEW-1:0] byte_q;
    logic             t_q, t_d;
    logic             done_q, done_d;
    logic             ill_q, ill_d;
    logic             load_ctx;

    logic [XLEN-1:0]  ea;
    logic             reg_bit, reg_nb, reg_nt;
    logic [XLEN-1:0]  reg_new;
    logic             mem_bit, mem_nb, mem_nt;
    logic [BYTEW-1:0] byte_new;

    bitop_decode u_dec (
        .insn_hi (insn_hi),
        .insn_lo (insn_lo),
        .dec     (dec)
    );

    // Register-form datapath
    bitop_lane #(.W(XLEN)) u_reg_lane (
        .din     (rf_rdata),
        .idx     ({{(RIW-3){1'b0}}, dec.idx}),
        .new_bit (reg_nb),
        .bit_sel (reg_bit),
        .dout    (reg_new)
    );

    bitop_alu u_reg_alu (
        .op      (dec.op),
        .bit_in  (reg_bit),
        .t_in    (t_q),
        .bit_out (reg_nb),
        .t_out   (reg_nt)
    );

    // Memory-form datapath, fed by the captured context
    bitop_lane #(.W(BYTEW)) u_byte_lane (
        .din     (mem_rdata),
        .idx     (BIW'(idx_q)),
        .new_bit (mem_nb),
        .bit_sel (mem_bit),
        .dout    (byte_new)
    );

    bitop_alu u_mem_alu (
        .op      (op_q),
        .bit_in  (mem_bit),
        .t_in    (t_q),
        .bit_out (mem_nb),
        .t_out   (mem_nt)
    );

    assign ea       = rf_rdata + XLEN'(dec.disp);
    assign rf_raddr = dec.rn;

    // State register and captured context
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            t_q     <= 1'b0;
            done_q  <= 1'b0;
            ill_q   <= 1'b0;
            op_q    <= BOP_BAD;
            idx_q   <= '0;
            addr_q  <= '0;
            byte_q  <= '0;
        end else begin
            state_q <= state_d;
            t_q     <= t_d;
            done_q  <= done_d;
            ill_q   <= ill_d;
            if (load_ctx) begin
                op_q   <= dec.op;
                idx_q  <= dec.idx;
                addr_q <= ea;
            end
            if (state_q == ST_CAPTURE) begin
                byte_q <= byte_new;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        t_d       = t_q;
        done_d    = 1'b0;
        ill_d     = 1'b0;
        load_ctx  = 1'b0;
        rf_we     = 1'b0;
        rf_waddr  = dec.rn;
        rf_wdata  = reg_new;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = addr_q;
        mem_wdata = byte_q;
        unique case (state_q)
            ST_IDLE: begin
                if (issue_valid) begin
                    if (!dec.legal) begin
                        done_d = 1'b1;
                        ill_d  = 1'b1;
                    end else if (!dec.mem_form) begin
                        rf_we  = op_writes(dec.op);
                        t_d    = reg_nt;
                        done_d = 1'b1;
                    end else begin
                        mem_re   = 1'b1;
                        mem_addr = ea;
                        load_ctx = 1'b1;
                        state_d  = ST_CAPTURE;
                    end
                end
            end
            ST_CAPTURE: begin
                t_d     = mem_nt;
                state_d = ST_WRITE;
            end
            ST_WRITE: begin
                mem_we  = op_writes(op_q);
                done_d  = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign illegal = ill_q;
    assign t_flag  = t_q;

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            done,
    input logic            illegal,
    input logic            t_flag,
    input logic            rf_we,
    input logic            mem_re,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_addr
);

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done && !t_flag && !mem_we));

    p_reg_write_keeps_t_r2: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> $stable(t_flag));

    p_read_enters_busy_r4: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> busy);

    p_write_same_addr_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($past(mem_re, 2) && (mem_addr == $past(mem_addr, 2)) && $stable(t_flag)));

    p_mem_three_cycles_r7: assert property (@(posedge clk) disable iff (rst)
        mem_re |-> ##3 done);

    p_reg_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> done);

    p_done_when_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_single_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rf_we, mem_re, mem_we}));

    p_quiet_while_busy_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!rf_we && !mem_re));

    p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (done && $past(!rf_we && !mem_re) && $stable(t_flag)));

endmodule

bind bitop_unit bitop_unit_chk #(.XLEN(XLEN)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .illegal  (illegal),
    .t_flag   (t_flag),
    .rf_we    (rf_we),
    .mem_re   (mem_re),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
);

// File: tb/bitop_unit_tb_top.sv
`timescale 1ns/1ps
module bitop_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic [15:0] insn_hi = '0;
    logic [15:0] insn_lo = '0;
    logic        busy, done, illegal, t_flag;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata;
    logic        rf_we, mem_re, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    always #2.5 clk = ~clk;

    bitop_unit dut_i (
        .clk(clk), .rst(rst), .issue_valid(issue_valid),
        .insn_hi(insn_hi), .insn_lo(insn_lo),
        .busy(busy), .done(done), .illegal(illegal), .t_flag(t_flag),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Bench-side register file and byte memory
    logic [31:0] regs [16];
    logic [7:0]  mem  [4096];
    logic [31:0] last_raddr = '0;
    int          wr_cnt = 0;

    assign rf_rdata = regs[rf_raddr];

    always @(posedge clk) begin
        if (rf_we) regs[rf_waddr] <= rf_wdata;
        if (mem_re) begin
            mem_rdata  <= mem[mem_addr[11:0]];
            last_raddr <= mem_addr;
        end
        if (mem_we) begin
            mem[mem_addr[11:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    int   n_chk  = 0;
    int   n_fail = 0;
    logic t_model = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic ref_t(input logic [3:0] nib, input logic b, input logic t);
        case (nib)
            4'h3: return b;
            4'h4: return b & t;
            4'h5: return b | t;
            4'h6: return b ^ t;
            4'hB: return ~b;
            4'hC: return ~b & t;
            4'hD: return ~b | t;
            default: return t;
        endcase
    endfunction

    function automatic logic ref_bit(input logic [3:0] nib, input logic b, input logic t);
        case (nib)
            4'h0: return 1'b0;
            4'h1: return 1'b1;
            4'h2: return t;
            default: return b;
        endcase
    endfunction

    function automatic logic nib_writes(input logic [3:0] nib);
        return nib <= 4'h2;
    endfunction

    function automatic logic nib_legal(input logic [3:0] nib);
        return (nib <= 4'h6) || (nib == 4'hB) || (nib == 4'hC) || (nib == 4'hD);
    endfunction

    task automatic exec(input logic [15:0] hi, input logic [15:0] lo,
                        output int lat, output logic ill);
        @(negedge clk);
        insn_hi     = hi;
        insn_lo     = lo;
        issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        ill = illegal;
    endtask

    task automatic do_reg(input logic [1:0] kind, input logic [3:0] rn, input logic [2:0] idx);
        logic [31:0] exp_r;
        logic        b, exp_t, ill;
        int          lat, w0;
        exp_r = regs[rn];
        b     = exp_r[idx];
        exp_t = ref_t({2'b00, kind}, b, t_model);
        if (kind != 2'd3) exp_r[idx] = ref_bit({2'b00, kind}, b, t_model);
        w0 = wr_cnt;
        exec({7'b1000011, kind[1], rn, kind[0], idx}, 16'h0000, lat, ill);
        if (kind == 2'd3) begin
            chk("R3 reg load T", {31'b0, t_flag}, {31'b0, exp_t});
            chk("R3 reg unchanged", regs[rn], exp_r);
        end else begin
            chk("R2 reg value", regs[rn], exp_r);
            chk("R2 T kept", {31'b0, t_flag}, {31'b0, exp_t});
        end
        chk("R7 reg latency", lat, 1);
        chk("R9 reg not illegal", {31'b0, ill}, 32'd0);
        chk("R7 reg no mem write", wr_cnt - w0, 0);
        t_model = exp_t;
    endtask

    task automatic do_mem(input logic [3:0] nib, input logic [3:0] rn, input logic [2:0] idx,
                          input logic [11:0] disp, input logic bad7);
        logic [31:0] addr;
        logic [7:0]  exp_b;
        logic        b, exp_t, legal, ill;
        int          lat, w0;
        addr  = regs[rn] + {20'b0, disp};
        exp_b = mem[addr[11:0]];
        b     = exp_b[idx];
        legal = !bad7 && nib_legal(nib);
        exp_t = t_model;
        if (legal) begin
            exp_t = ref_t(nib, b, t_model);
            if (nib_writes(nib)) exp_b[idx] = ref_bit(nib, b, t_model);
        end
        w0 = wr_cnt;
        exec({4'h3, rn, bad7, idx, 4'h9}, {nib, disp}, lat, ill);
        chk("R9 illegal flag", {31'b0, ill}, {31'b0, !legal});
        if (legal) begin
            chk("R4 address", last_raddr, addr);
            chk("R7 mem latency", lat, 3);
            chk("R5 T result", {31'b0, t_flag}, {31'b0, exp_t});
            chk("R6 byte value", {24'b0, mem[addr[11:0]]}, {24'b0, exp_b});
            chk("R5 R6 write count", wr_cnt - w0, nib_writes(nib) ? 1 : 0);
        end else begin
            chk("R9 latency", lat, 1);
            chk("R9 T kept", {31'b0, t_flag}, {31'b0, exp_t});
            chk("R9 byte kept", {24'b0, mem[addr[11:0]]}, {24'b0, exp_b});
            chk("R9 no write", wr_cnt - w0, 0);
        end
        t_model = exp_t;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int          lat;
        logic        ill;
        logic [3:0]  legal_nibs [10];
        logic [3:0]  bad_nibs   [6];
        legal_nibs = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hB, 4'hC, 4'hD};
        bad_nibs   = '{4'h7, 4'h8, 4'h9, 4'hA, 4'hE, 4'hF};
        void'($urandom(32'h5EED_0B17));
        for (int i = 0; i < 16; i++) regs[i] = $urandom;
        for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
        mem_rdata = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 T after reset", {31'b0, t_flag}, 32'd0);
        chk("R1 busy/done after reset", {30'b0, busy, done}, 32'd0);
        chk("R1 strobes after reset", {28'b0, illegal, rf_we, mem_re, mem_we}, 32'd0);

        // Directed: register forms at the edge bit positions
        regs[1] = 32'h0000_0000;
        do_reg(2'd1, 4'd1, 3'd7);   // set bit 7
        do_reg(2'd3, 4'd1, 3'd7);   // T <- 1
        do_reg(2'd2, 4'd1, 3'd0);   // bit 0 <- T
        do_reg(2'd0, 4'd1, 3'd7);   // clear bit 7
        do_reg(2'd3, 4'd1, 3'd6);   // T <- 0
        chk("R2 combined reg value", regs[1], 32'h0000_0001);

        // Directed: inverted variants with both T values
        regs[3] = 32'h0000_0100;
        mem[12'h100] = 8'h80;
        do_mem(4'hB, 4'd3, 3'd7, 12'h000, 1'b0);  // T <- ~1 = 0
        do_mem(4'hD, 4'd3, 3'd0, 12'h000, 1'b0);  // T <- ~0 | 0 = 1
        do_mem(4'hC, 4'd3, 3'd7, 12'h000, 1'b0);  // T <- ~1 & 1 = 0
        do_mem(4'h2, 4'd3, 3'd0, 12'h000, 1'b0);  // bit0 <- 0
        chk("R6 directed byte", {24'b0, mem[12'h100]}, 32'h0000_0080);

        // Directed: address wrap with top displacement
        regs[4] = 32'hFFFF_F000;
        do_mem(4'h1, 4'd4, 3'd3, 12'hFFF, 1'b0);
        chk("R4 wrap address", last_raddr, 32'hFFFF_FFFF);

        // Directed: illegal patterns
        do_mem(4'h7, 4'd2, 3'd1, 12'h010, 1'b0);
        do_mem(4'h0, 4'd2, 3'd1, 12'h010, 1'b1);
        exec(16'h0009, 16'h0000, lat, ill);
        chk("R9 unknown halfword", {31'b0, ill}, 32'd1);
        chk("R9 unknown halfword T", {31'b0, t_flag}, {31'b0, t_model});

        // Directed: issue while busy is ignored
        regs[2] = 32'h0000_0000;
        @(negedge clk);
        insn_hi = {4'h3, 4'd3, 1'b0, 3'd2, 4'h9};
        insn_lo = {4'h3, 12'h004};
        issue_valid = 1'b1;
        @(negedge clk);
        chk("R8 busy in sequence", {31'b0, busy}, 32'd1);
        insn_hi = {7'b1000011, 1'b0, 4'd2, 1'b1, 3'd0};
        insn_lo = 16'h0000;
        @(negedge clk);
        issue_valid = 1'b0;
        @(negedge clk);
        chk("R8 done after sequence", {31'b0, done}, 32'd1);
        t_model = t_flag;
        @(negedge clk);
        chk("R8 ignored issue left reg", regs[2], 32'h0000_0000);

        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            int sel;
            sel = int'($urandom % 10);
            if (sel < 3) begin
                do_reg(2'($urandom), 4'($urandom), 3'($urandom));
            end else if (sel < 9) begin
                do_mem(legal_nibs[$urandom % 10], 4'($urandom), 3'($urandom),
                       12'($urandom), 1'b0);
            end else if ($urandom % 2 == 0) begin
                do_mem(bad_nibs[$urandom % 6], 4'($urandom), 3'($urandom),
                       12'($urandom), 1'b0);
            end else begin
                do_mem(legal_nibs[$urandom % 10], 4'($urandom), 3'($urandom),
                       12'($urandom), 1'b1);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule